// File: doc/BRIEF.md
# Reload-Match Timer PWM Generator

An up-counting timer that drives a single pulse-width-modulated pin. Each time the counter reaches its all-ones maximum it wraps by reloading a programmed start value, so the period length is the distance between that start value and the maximum. A second programmed value is compared against the running count; when the count reaches it, the pin drops to its inactive level for the rest of the period. A one-cycle overflow pulse marks every period boundary.

Software programs the timer through a single write port with a two-bit register select. For a period of P ticks it writes the start value MAX - P + 1. For an active time of D ticks it writes the compare value start + D - 1. Start value and compare value may be rewritten while the timer runs. They are held in shadow storage and moved into use together on the next boundary, so a period never mixes an old setting with a new one. The configuration fields are frozen while the timer runs; only the run bit can still be changed, so the timer can be stopped.

Top module: `rm_pwm_timer`

## Requirements
- R1: Reset sets the state as follows. The timer is stopped with all configuration bits clear. The count, the start value and the compare value are zero. `pwm_out` is 0 and `ovf_pulse` is 0.
- R2: While running with auto-reload on, the count wraps when it reaches the all-ones maximum. The reload value is the stored start value L. Overflow pulses therefore arrive exactly MAX - L + 1 cycles apart.
- R3: With compare enabled and compare value M in the range L to MAX, the output is active for M - L + 1 cycles of each period, starting at the reload cycle. It is inactive for the rest of the period.
- R4: Polarity bit 1 makes the active level low and the inactive level high. Polarity 0 makes the active level high.
- R5: While running, a control write can change only the run bit. Writes to the auto-reload, compare-enable and polarity bits have no effect.
- R6: A start-value or compare-value write made during a period leaves that period's length and active time unchanged. While the timer is stopped, written values come into use at once.
- R7: Start value and compare value come into use together on the same overflow. The first period after a mid-period rewrite of both shows the new length and the new active time.
- R8: Two cases give an output that is active for the whole period: a compare value outside L to MAX, and compare disabled.
- R9: With auto-reload off, the overflow reloads the count and clears the run bit. After that, no more overflow pulses occur and the output sits at its inactive level.
- R10: Clearing the run bit freezes the count and forces the output inactive. Setting the run bit again resumes counting from the frozen value, so the next overflow comes after the ticks that remained in the period. The output stays active until the next compare hit or overflow.
- R11: A counter write takes effect on the next clock edge, even while running, and suppresses the overflow on that edge.
- R12: `ovf_pulse` is high for exactly the one cycle after the count was at its maximum. In that cycle the count holds the reload value.
- R13: `wr_sel` encoding: 0 selects control, 1 counter, 2 start value, 3 compare value. Control bits: bit 0 run, bit 1 auto-reload, bit 2 compare enable, bit 3 polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (R13) |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | PWM pin |
| ovf_pulse | output | 1 | One-cycle period-boundary pulse |

## Verification
The bench rewrites start and compare values at random points inside a period and measures that period and the one after it. A design that applied the values at once, or that copied them on different edges, would show a boundary period with the wrong length or the old duty. Corner settings are covered: duty equal to the period, a one-tick duty, a compare value below the start value, and compare disabled. An off-by-one in the compare or a missing priority of overflow over compare would show up as one extra or missing active cycle. Stop and restart mid-period, a one-shot run and a counter write close to the maximum are timed to the exact cycle, which exposes counters that keep ticking while stopped or that reload from the wrong value.

// File: rtl/rm_pwm_pkg.sv
package rm_pwm_pkg;

    localparam int CTRL_BITS = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_LOAD  = 2'd2,
        SEL_MATCH = 2'd3
    } reg_sel_e;

    // bit3 polarity, bit2 compare enable, bit1 auto-reload, bit0 run
    typedef struct packed {
        logic pol;
        logic cmp_en;
        logic auto_rl;
        logic run;
    } ctrl_t;

    // While running only the run bit accepts a new value.
    function automatic ctrl_t ctrl_write(ctrl_t cur, logic [CTRL_BITS-1:0] wd);
        ctrl_t nx;
        nx = ctrl_t'(wd);
        if (cur.run) begin
            nx     = cur;
            nx.run = wd[0];
        end
        return nx;
    endfunction

endpackage

// File: rtl/rm_pwm_ctrl.sv
module rm_pwm_ctrl
    import rm_pwm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ctrl,
    input  logic [CTRL_BITS-1:0] wr_bits,
    input  logic                 ovf_tick,
    output ctrl_t                ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_write(ctrl, wr_bits);
        end else if (ovf_tick && !ctrl.auto_rl) begin
            ctrl.run <= 1'b0;
        end
    end

endmodule

// File: rtl/rm_pwm_shadow.sv
module rm_pwm_shadow #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_load,
    input  logic         wr_match,
    input  logic [W-1:0] wr_data,
    input  logic         running,
    input  logic         ovf_tick,
    output logic [W-1:0] sh_load,
    output logic [W-1:0] act_match
);

    logic [W-1:0] sh_match;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_load   <= '0;
            sh_match  <= '0;
            act_match <= '0;
        end else begin
            if (wr_load)  sh_load  <= wr_data;
            if (wr_match) sh_match <= wr_data;
            // The pair moves into use on the boundary; the start value is
            // consumed by the counter on that same edge.
            if (!running || ovf_tick) act_match <= sh_match;
        end
    end

endmodule

// File: rtl/rm_pwm_core.sv
module rm_pwm_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         cmp_en,
    input  logic         pol,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] sh_load,
    input  logic [W-1:0] act_match,
    output logic [W-1:0] cnt,
    output logic         ovf_tick,
    output logic         ovf_pulse,
    output logic         pwm_out
);

    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = W'(1);

    logic lvl;
    logic hit;

    assign ovf_tick = run && !cnt_wr && (cnt == CNT_MAX);
    assign hit      = cmp_en && (cnt == act_match);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            lvl       <= 1'b1;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= ovf_tick;
            if (cnt_wr)        cnt <= wr_data;
            else if (ovf_tick) cnt <= sh_load;
            else if (run)      cnt <= cnt + CNT_ONE;

            if (!run)                  lvl <= 1'b1;
            else if (ovf_tick)         lvl <= 1'b1;
            else if (!cnt_wr && hit)   lvl <= 1'b0;
        end
    end

    assign pwm_out = pol ^ (run & lvl);

endmodule

// File: rtl/rm_pwm_timer.sv
module rm_pwm_timer
    import rm_pwm_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    output logic         pwm_out,
    output logic         ovf_pulse
);

    reg_sel_e     sel;
    ctrl_t        ctrl_q;
    logic         wr_ctrl, wr_count, wr_load, wr_match;
    logic         ovf_tick;
    logic [W-1:0] cnt_q, sh_load, act_match;

    assign sel      = reg_sel_e'(wr_sel);
    assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
    assign wr_count = wr_en && (sel == SEL_COUNT);
    assign wr_load  = wr_en && (sel == SEL_LOAD);
    assign wr_match = wr_en && (sel == SEL_MATCH);

    rm_pwm_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_ctrl),
        .wr_bits  (wr_data[CTRL_BITS-1:0]),
        .ovf_tick (ovf_tick),
        .ctrl     (ctrl_q)
    );

    rm_pwm_shadow #(.W(W)) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_load   (wr_load),
        .wr_match  (wr_match),
        .wr_data   (wr_data),
        .running   (ctrl_q.run),
        .ovf_tick  (ovf_tick),
        .sh_load   (sh_load),
        .act_match (act_match)
    );

    rm_pwm_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .cmp_en    (ctrl_q.cmp_en),
        .pol       (ctrl_q.pol),
        .cnt_wr    (wr_count),
        .wr_data   (wr_data),
        .sh_load   (sh_load),
        .act_match (act_match),
        .cnt       (cnt_q),
        .ovf_tick  (ovf_tick),
        .ovf_pulse (ovf_pulse),
        .pwm_out   (pwm_out)
    );

endmodule

// File: rtl/rm_pwm_checker.sv
module rm_pwm_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         run,
    input logic         auto_rl,
    input logic         cmp_en,
    input logic         pol,
    input logic         cnt_wr,
    input logic [W-1:0] cnt,
    input logic [W-1:0] sh_load,
    input logic [W-1:0] act_match,
    input logic         ovf_pulse,
    input logic         pwm_out
);

    localparam logic [W-1:0] CNT_MAX = '1;

    p_ovf_cause_r12: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> ($past(run) && ($past(cnt) == CNT_MAX) && !$past(cnt_wr)));

    p_reload_value_r2: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> (cnt == $past(sh_load)));

    p_oneshot_stop_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_pulse && !auto_rl) |-> !run);

    p_cfg_locked_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run) |-> ($stable(auto_rl) && $stable(cmp_en) && $stable(pol)));

    p_stopped_output_r10: assert property (@(posedge clk) disable iff (rst)
        !run |-> (pwm_out == pol));

    p_frozen_count_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(cnt_wr)) |-> (cnt == $past(cnt)));

    p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run && !ovf_pulse) |-> (act_match == $past(act_match)));

endmodule

bind rm_pwm_timer rm_pwm_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl_q.run),
    .auto_rl   (ctrl_q.auto_rl),
    .cmp_en    (ctrl_q.cmp_en),
    .pol       (ctrl_q.pol),
    .cnt_wr    (wr_count),
    .cnt       (cnt_q),
    .sh_load   (sh_load),
    .act_match (act_match),
    .ovf_pulse (ovf_pulse),
    .pwm_out   (pwm_out)
);

// File: tb/tb_rm_pwm_timer.sv
`timescale 1ns/1ps
module tb_rm_pwm_timer;

    localparam int W = 32;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         pwm_out, ovf_pulse;

    int   total = 0;
    int   bad = 0;
    logic pol_exp = 1'b0;

    always #2 clk = ~clk;

    rm_pwm_timer #(.W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out), .ovf_pulse(ovf_pulse)
    );

    function automatic logic [W-1:0] ld_of(int p);
        return MAXV - W'(p) + W'(1);
    endfunction

    function automatic logic [W-1:0] mt_of(int p, int d);
        return ld_of(p) + W'(d) - W'(1);
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_ovf(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (ovf_pulse) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    // Precondition: at a negedge where ovf_pulse is high (period start).
    task automatic run_period(input int k, input bit do_wr,
                              input logic [W-1:0] nl, input logic [W-1:0] nm,
                              output int len, output int hi);
        len = 0; hi = 0;
        for (int i = 0; i < 1000; i++) begin
            if (pwm_out != pol_exp) hi++;
            len++;
            wr_en = 1'b0;
            if (do_wr && i == k)     begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = nl; end
            if (do_wr && i == k + 1) begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = nm; end
            @(negedge clk);
            if (ovf_pulse) break;
        end
        wr_en = 1'b0;
    endtask

    task automatic restart(input logic [3:0] c, input logic [W-1:0] ld,
                           input logic [W-1:0] mt, input logic [W-1:0] c0);
        wr(2'd0, '0);
        wr(2'd2, ld);
        wr(2'd3, mt);
        wr(2'd1, c0);
        pol_exp = c[3];
        wr(2'd0, W'(c));
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL R2 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit ok;
        int len, hi, c, errs;
        int cur_p, cur_d, np, nd, k;
        void'($urandom(32'd5150));

        repeat (4) @(negedge clk);
        check("R1", "pwm_out in reset", int'(pwm_out), 0);
        check("R1", "ovf_pulse in reset", int'(ovf_pulse), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "pwm_out after reset", int'(pwm_out), 0);

        // R13 encoding: run|auto|cmp = 4'b0111
        restart(4'b0111, ld_of(8), mt_of(8, 3), MAXV);
        wait_ovf(ok);
        check("R2", "first overflow seen", int'(ok), 1);
        @(negedge clk);
        check("R12", "pulse one cycle wide", int'(ovf_pulse), 0);
        wait_ovf(ok);
        run_period(0, 1'b0, '0, '0, len, hi);
        check("R2", "period length P=8", len, 8);
        check("R3", "active cycles D=3", hi, 3);

        // R5: running, try to set polarity and drop auto-reload/compare
        wr(2'd0, W'(4'b1001));
        wait_ovf(ok);
        run_period(0, 1'b0, '0, '0, len, hi);
        check("R5", "period after locked write", len, 8);
        check("R5", "duty/polarity after locked write", hi, 3);

        // R6 / R7: random mid-period updates
        cur_p = 8; cur_d = 3;
        for (int it = 0; it < 14; it++) begin
            if (it == 12)      begin np = 5; nd = 5; end
            else if (it == 13) begin np = 6; nd = 1; end
            else begin
                np = 4 + int'($urandom_range(36));
                nd = 1 + int'($urandom_range(np - 1));
            end
            k = int'($urandom_range(cur_p - 4));
            run_period(k, 1'b1, ld_of(np), mt_of(np, nd), len, hi);
            check("R6", "old period kept", len, cur_p);
            check("R6", "old duty kept", hi, cur_d);
            run_period(0, 1'b0, '0, '0, len, hi);
            check("R7", "new period applied", len, np);
            check("R7", "new duty applied", hi, nd);
            cur_p = np; cur_d = nd;
        end

        // R8: compare value below start value
        restart(4'b0111, ld_of(10), ld_of(10) - W'(1), MAXV);
        wait_ovf(ok);
        run_period(0, 1'b0, '0, '0, len, hi);
        check("R8", "period with out-of-range match", len, 10);
        check("R8", "fully active out-of-range", hi, 10);
        // R8: compare disabled
        restart(4'b0011, ld_of(10), mt_of(10, 4), MAXV);
        wait_ovf(ok);
        run_period(0, 1'b0, '0, '0, len, hi);
        check("R8", "fully active compare off", hi, 10);

        // R4: inverted polarity
        restart(4'b1111, ld_of(8), mt_of(8, 3), MAXV);
        wait_ovf(ok);
        run_period(0, 1'b0, '0, '0, len, hi);
        check("R4", "inverted period", len, 8);
        check("R4", "inverted low cycles", hi, 3);
        wr(2'd0, '0);
        check("R4", "stopped level with polarity 1", int'(pwm_out), 1);

        // R10: stop mid-period, restart, remaining ticks
        restart(4'b0111, ld_of(10), mt_of(10, 4), MAXV);
        wait_ovf(ok);
        repeat (3) @(negedge clk);
        wr(2'd0, '0);
        errs = 0;
        for (int i = 0; i < 20; i++) begin
            if (pwm_out != 1'b0 || ovf_pulse) errs++;
            @(negedge clk);
        end
        check("R10", "stopped cycles inactive without pulses", errs, 0);
        wr(2'd0, W'(4'b0111));
        c = 0;
        for (int i = 0; i < 100 && !ovf_pulse; i++) begin
            c++;
            @(negedge clk);
        end
        check("R10", "cycles to overflow after restart", c, 6);

        // R11: counter write while running
        wr(2'd1, MAXV - W'(1));
        c = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            c++;
            if (ovf_pulse) break;
        end
        check("R11", "steps from counter write to overflow", c, 2);

        // R9: one-shot
        restart(4'b0101, ld_of(6), mt_of(6, 2), ld_of(6));
        c = 0;
        for (int i = 0; i < 100 && !ovf_pulse; i++) begin
            c++;
            @(negedge clk);
        end
        check("R9", "one-shot length", c, 6);
        check("R9", "inactive at one-shot end", int'(pwm_out), 0);
        errs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out != 1'b0 || ovf_pulse) errs++;
        end
        check("R9", "no activity after one-shot", errs, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule